// File: doc/BRIEF.md
# Bank-Lookahead SDRAM Command Scheduler

This block turns an ordered stream of burst requests into SDRAM commands, one command per controller clock. Each request names a direction (read or write), a bank, a row and a column. The block keeps an open flag and the open row for every bank. A request that hits an open row goes straight to a column command. Any other request first gets a precharge and/or an activate.

The request queue itself sits outside the block, which sees only its first two entries. While the head request is still waiting for its column slot, the block looks at the second entry. If that entry targets a different bank, the block opens the right row there. It uses the otherwise idle clocks between column commands for this, so a run of transfers can cross from one bank to the next at the full column rate.

Timing rules are held in per-bank down-counters set by parameters:
- activate to column,
- precharge to activate,
- activate to precharge.

A global pacer enforces the column spacing and an extra gap whenever the direction changes. A parameter selects half-rate operation. In that mode a command may be issued only on every second clock, which leaves one spare slot between column commands instead of three.

Top module: `bank_lookahead_sched`

## Requirements
- R1: While reset is asserted, the command output is NOP (code 0) and `hd_pop` is low.
- R2: When no head request is offered, the output is NOP and every open row stays open. A later request to such a row gets a column command with no precharge or activate before it.
- R3: Command codes are NOP=0, ACT=1, PRE=2, RD=3, WR=4. The address output carries the row on ACT, the column on RD/WR, and 0 on PRE/NOP. A request to a closed bank gets ACT first, and its column command follows exactly T_RCD clocks later when nothing else holds it back.
- R4: Column commands follow request order. In a stream of same-direction row hits they are exactly COL_GAP clocks apart.
- R5: An activate for the next request's bank may be issued in the clock right after a write column command, while that burst is still in flight.
- R6: When the next request needs another row in a different bank, PRE and then ACT for that bank are placed in the gaps of the current bank's column stream. The first column to the new bank then comes exactly COL_GAP clocks after the last column to the old bank.
- R7: Consecutive column commands of opposite direction are at least COL_GAP+TURN_GAP clocks apart. When nothing else holds them back, they are exactly that far apart.
- R8: For each bank, PRE comes no sooner than T_RAS clocks after its ACT, and ACT comes no sooner than T_RP clocks after its PRE.
- R9: With HALF_RATE set, all commands fall on alternate clocks, so any two non-NOP commands are an even number of clocks apart.
- R10: `hd_pop` is high in exactly the decision clock of each column command, once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_vld | input | 1 | Head request present |
| hd_wr | input | 1 | Head request is a write |
| hd_bank | input | BANK_W | Head request bank |
| hd_row | input | ROW_W | Head request row |
| hd_col | input | COL_W | Head request column |
| nx_vld | input | 1 | Second queued request present |
| nx_bank | input | BANK_W | Second request bank |
| nx_row | input | ROW_W | Second request row |
| hd_pop | output | 1 | Head request consumed this clock |
| cmd_o | output | 3 | Registered command code |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row or column of the command |

## Verification
The bench applies a set of request streams, each chosen to separate one scheduling decision from the others:
- A write stream that crosses into a closed bank shows whether the lookahead activate lands in the clock after a write and keeps the column spacing unbroken.
- A read stream whose last request needs a different row in an open bank shows precharge and activate being fitted into the gaps.
- A read/write/write/read pattern on open rows isolates the turnaround gap, and shows that rows stay open across idle time.
- Two requests to different rows of the same bank expose the activate-to-precharge and precharge-to-activate limits, since no lookahead can hide them.
- The first stream is then replayed on a half-rate instance, to confirm that commands land only on alternate clocks.

// File: rtl/lasch_pkg.sv
`timescale 1ns/1ps
package lasch_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_PRE = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } lasch_cmd_e;

   function automatic int unsigned lasch_max3(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lasch_bank_state.sv
`timescale 1ns/1ps
module lasch_bank_state #(
   parameter int unsigned NBANK = 8,
   parameter int unsigned ROW_W = 15,
   parameter int unsigned T_RCD = 5,
   parameter int unsigned T_RP  = 5,
   parameter int unsigned T_RAS = 12,
   localparam int unsigned BANK_W = $clog2(NBANK)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        iss_act,
   input  logic                        iss_pre,
   input  logic [BANK_W-1:0]           iss_bank,
   input  logic [ROW_W-1:0]            iss_row,
   output logic [NBANK-1:0]            open_o,
   output logic [NBANK-1:0]            act_ok_o,
   output logic [NBANK-1:0]            pre_ok_o,
   output logic [NBANK-1:0]            col_ok_o,
   output logic [NBANK-1:0][ROW_W-1:0] row_o
);
   import lasch_pkg::*;

   localparam int unsigned TMAX = lasch_max3(T_RCD, T_RP, T_RAS);
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] RCD_LD = TW'(T_RCD - 1);
   localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 1);
   localparam logic [TW-1:0] RAS_LD = TW'(T_RAS - 1);

   initial begin
      assert (T_RCD >= 1 && T_RP >= 1 && T_RAS >= 1)
         else $error("bank timing limits must be at least one clock");
      assert (NBANK >= 2 && (1 << BANK_W) == NBANK)
         else $error("bank count must be a power of two");
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic              here;
      logic              open_q;
      logic [ROW_W-1:0]  row_q;
      logic [TW-1:0]     rcd_q, rp_q, ras_q;

      assign here = (iss_bank == BANK_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            rp_q   <= '0;
            ras_q  <= '0;
         end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
            if (iss_act && here) begin
               open_q <= 1'b1;
               row_q  <= iss_row;
               rcd_q  <= RCD_LD;
               ras_q  <= RAS_LD;
            end
            if (iss_pre && here) begin
               open_q <= 1'b0;
               rp_q   <= RP_LD;
            end
         end
      end

      assign open_o[g]   = open_q;
      assign row_o[g]    = row_q;
      assign act_ok_o[g] = (rp_q == '0);
      assign pre_ok_o[g] = (ras_q == '0);
      assign col_ok_o[g] = (rcd_q == '0);

      // R8
      act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_act && here) |-> (!open_q && rp_q == '0));

      // R8
      pre_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_pre && here) |-> (open_q && ras_q == '0));
   end

endmodule

// File: rtl/lasch_col_pacer.sv
`timescale 1ns/1ps
module lasch_col_pacer #(
   parameter int unsigned COL_GAP   = 4,
   parameter int unsigned TURN_GAP  = 2,
   parameter bit          HALF_RATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic col_iss,
   input  logic col_wr,
   input  logic want_wr,
   output logic gap_ok,
   output logic slot_ok
);
   localparam int unsigned SPAN  = COL_GAP + TURN_GAP;
   localparam int unsigned AGE_W = $clog2(SPAN + 1);
   localparam logic [AGE_W-1:0] AMAX      = AGE_W'(SPAN - 1);
   localparam logic [AGE_W-1:0] SAME_NEED = AGE_W'(COL_GAP - 1);
   localparam logic [AGE_W-1:0] TURN_NEED = AGE_W'(SPAN - 1);

   initial begin
      assert (COL_GAP >= 2) else $error("column spacing must be two clocks or more");
   end

   logic [AGE_W-1:0] age_q;
   logic             last_wr_q;
   logic [AGE_W-1:0] need;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q     <= AMAX;
         last_wr_q <= 1'b0;
      end else if (col_iss) begin
         age_q     <= '0;
         last_wr_q <= col_wr;
      end else if (age_q < AMAX) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign need   = (want_wr != last_wr_q) ? TURN_NEED : SAME_NEED;
   assign gap_ok = (age_q >= need);

   if (HALF_RATE) begin : g_half
      logic phase_q;
      always_ff @(posedge clk) begin
         if (!rst_n) phase_q <= 1'b0;
         else        phase_q <= ~phase_q;
      end
      assign slot_ok = ~phase_q;
   end else begin : g_full
      assign slot_ok = 1'b1;
   end

   // R4
   col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_iss |=> !col_iss);

endmodule

// File: rtl/bank_lookahead_sched.sv
`timescale 1ns/1ps
module bank_lookahead_sched #(
   parameter int unsigned NBANK     = 8,
   parameter int unsigned ROW_W     = 15,
   parameter int unsigned COL_W     = 10,
   parameter int unsigned T_RCD     = 5,
   parameter int unsigned T_RP      = 5,
   parameter int unsigned T_RAS     = 12,
   parameter int unsigned COL_GAP   = 4,
   parameter int unsigned TURN_GAP  = 2,
   parameter bit          HALF_RATE = 1'b0,
   localparam int unsigned BANK_W = $clog2(NBANK),
   localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hd_vld,
   input  logic              hd_wr,
   input  logic [BANK_W-1:0] hd_bank,
   input  logic [ROW_W-1:0]  hd_row,
   input  logic [COL_W-1:0]  hd_col,
   input  logic              nx_vld,
   input  logic [BANK_W-1:0] nx_bank,
   input  logic [ROW_W-1:0]  nx_row,
   output logic              hd_pop,
   output logic [2:0]        cmd_o,
   output logic [BANK_W-1:0] cmd_bank_o,
   output logic [ADDR_W-1:0] cmd_addr_o
);
   import lasch_pkg::*;

   logic [NBANK-1:0]            open_v, act_ok_v, pre_ok_v, col_ok_v;
   logic [NBANK-1:0][ROW_W-1:0] row_v;
   logic                        gap_ok, slot_ok;

   lasch_cmd_e        dec_cmd;
   logic [BANK_W-1:0] dec_bank;
   logic [ADDR_W-1:0] dec_addr;
   logic              col_go;
   logic              h_open, h_hit, n_open, n_hit;

   lasch_cmd_e        cmd_q;
   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] addr_q;

   lasch_bank_state #(
      .NBANK (NBANK),
      .ROW_W (ROW_W),
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .T_RAS (T_RAS)
   ) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_act  (dec_cmd == CMD_ACT),
      .iss_pre  (dec_cmd == CMD_PRE),
      .iss_bank (dec_bank),
      .iss_row  (dec_addr[ROW_W-1:0]),
      .open_o   (open_v),
      .act_ok_o (act_ok_v),
      .pre_ok_o (pre_ok_v),
      .col_ok_o (col_ok_v),
      .row_o    (row_v)
   );

   lasch_col_pacer #(
      .COL_GAP   (COL_GAP),
      .TURN_GAP  (TURN_GAP),
      .HALF_RATE (HALF_RATE)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .col_iss (col_go),
      .col_wr  (hd_wr),
      .want_wr (hd_wr),
      .gap_ok  (gap_ok),
      .slot_ok (slot_ok)
   );

   assign h_open = open_v[hd_bank];
   assign h_hit  = h_open && (row_v[hd_bank] == hd_row);
   assign n_open = open_v[nx_bank];
   assign n_hit  = n_open && (row_v[nx_bank] == nx_row);

   // Head request first; lookahead on the second entry only when the head
   // issues nothing this clock and the second entry uses another bank.
   always_comb begin
      dec_cmd  = CMD_NOP;
      dec_bank = hd_bank;
      dec_addr = '0;
      col_go   = 1'b0;
      if (hd_vld && slot_ok) begin
         if (h_hit) begin
            if (col_ok_v[hd_bank] && gap_ok) begin
               col_go   = 1'b1;
               dec_cmd  = hd_wr ? CMD_WR : CMD_RD;
               dec_addr = ADDR_W'(hd_col);
            end
         end else if (h_open) begin
            if (pre_ok_v[hd_bank]) dec_cmd = CMD_PRE;
         end else if (act_ok_v[hd_bank]) begin
            dec_cmd  = CMD_ACT;
            dec_addr = ADDR_W'(hd_row);
         end
         if (dec_cmd == CMD_NOP && nx_vld && nx_bank != hd_bank) begin
            if (n_open && !n_hit) begin
               if (pre_ok_v[nx_bank]) begin
                  dec_cmd  = CMD_PRE;
                  dec_bank = nx_bank;
               end
            end else if (!n_open && act_ok_v[nx_bank]) begin
               dec_cmd  = CMD_ACT;
               dec_bank = nx_bank;
               dec_addr = ADDR_W'(nx_row);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         bank_q <= '0;
         addr_q <= '0;
      end else begin
         cmd_q  <= dec_cmd;
         bank_q <= dec_bank;
         addr_q <= dec_addr;
      end
   end

   assign hd_pop     = col_go;
   assign cmd_o      = cmd_q;
   assign cmd_bank_o = bank_q;
   assign cmd_addr_o = addr_q;

   // R2
   idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hd_vld |=> (cmd_q == CMD_NOP));

   // R10
   pop_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hd_pop |=> (cmd_q == CMD_RD || cmd_q == CMD_WR));

   // R3
   col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_v[bank_q]);

   if (HALF_RATE) begin : g_half_chk
      // R9
      alt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_q != CMD_NOP) |-> !slot_ok);
   end

endmodule

// File: tb/bank_lookahead_sched_tb_top.sv
`timescale 1ns/1ps
module bank_lookahead_sched_tb_top;

   localparam int NB = 8;
   localparam int RW = 12;
   localparam int CW = 8;
   localparam int BW = 3;
   localparam int AW = 12;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   int   sel = 0;
   int   idx = 0;
   int   qn  = 0;
   logic q_wr [8];
   int   q_bank [8];
   int   q_row [8];
   int   q_col [8];

   logic          hd_ok, nx_ok, hd_wr;
   logic [BW-1:0] hd_bank, nx_bank;
   logic [RW-1:0] hd_row, nx_row;
   logic [CW-1:0] hd_col;

   always_comb begin
      hd_ok = 1'b0; nx_ok = 1'b0; hd_wr = 1'b0;
      hd_bank = '0; hd_row = '0; hd_col = '0; nx_bank = '0; nx_row = '0;
      if (idx < qn && idx < 8) begin
         hd_ok = 1'b1;
         hd_wr = q_wr[idx];
         hd_bank = BW'(q_bank[idx]);
         hd_row = RW'(q_row[idx]);
         hd_col = CW'(q_col[idx]);
      end
      if (idx + 1 < qn && idx + 1 < 8) begin
         nx_ok = 1'b1;
         nx_bank = BW'(q_bank[idx+1]);
         nx_row = RW'(q_row[idx+1]);
      end
   end

   logic          pop_f, pop_h;
   logic [2:0]    cmd_f, cmd_h;
   logic [BW-1:0] bank_f, bank_h;
   logic [AW-1:0] addr_f, addr_h;

   bank_lookahead_sched #(
      .NBANK(NB), .ROW_W(RW), .COL_W(CW), .T_RCD(3), .T_RP(3), .T_RAS(6),
      .COL_GAP(4), .TURN_GAP(2), .HALF_RATE(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .hd_vld(hd_ok && sel == 0), .hd_wr(hd_wr), .hd_bank(hd_bank),
      .hd_row(hd_row), .hd_col(hd_col),
      .nx_vld(nx_ok && sel == 0), .nx_bank(nx_bank), .nx_row(nx_row),
      .hd_pop(pop_f), .cmd_o(cmd_f), .cmd_bank_o(bank_f), .cmd_addr_o(addr_f)
   );

   bank_lookahead_sched #(
      .NBANK(NB), .ROW_W(RW), .COL_W(CW), .T_RCD(3), .T_RP(3), .T_RAS(6),
      .COL_GAP(4), .TURN_GAP(2), .HALF_RATE(1'b1)
   ) dut_h (
      .clk(clk), .rst_n(rst_n),
      .hd_vld(hd_ok && sel == 1), .hd_wr(hd_wr), .hd_bank(hd_bank),
      .hd_row(hd_row), .hd_col(hd_col),
      .nx_vld(nx_ok && sel == 1), .nx_bank(nx_bank), .nx_row(nx_row),
      .hd_pop(pop_h), .cmd_o(cmd_h), .cmd_bank_o(bank_h), .cmd_addr_o(addr_h)
   );

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   int lg_n, npop;
   int lg_cyc [32];
   int lg_cmd [32];
   int lg_bank [32];
   int lg_addr [32];
   int e_cmd [16];
   int e_bank [16];
   int e_addr [16];
   int e_rel [16];

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put(input int i, input int c, input int b, input int a, input int r);
      e_cmd[i] = c; e_bank[i] = b; e_addr[i] = a; e_rel[i] = r;
   endtask

   task automatic push(input int i, input logic w, input int b, input int r, input int c);
      q_wr[i] = w; q_bank[i] = b; q_row[i] = r; q_col[i] = c;
   endtask

   task automatic run_q(input int s, input int n, input int ncyc);
      int  c;
      logic p;
      sel = s; idx = 0; qn = n; lg_n = 0; npop = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         c = (s == 1) ? int'(cmd_h) : int'(cmd_f);
         if (c != 0 && lg_n < 32) begin
            lg_cyc[lg_n]  = k;
            lg_cmd[lg_n]  = c;
            lg_bank[lg_n] = (s == 1) ? int'(bank_h) : int'(bank_f);
            lg_addr[lg_n] = (s == 1) ? int'(addr_h) : int'(addr_f);
            lg_n++;
         end
         p = (s == 1) ? pop_h : pop_f;
         if (p) npop++;
         @(posedge clk);
         #1;
         if (p) idx = idx + 1;
      end
   endtask

   task automatic cmp_trace(input string tag, input int n, input int nreq);
      chk({tag, " command count"}, lg_n, n);
      chk({tag, " pops (R10)"}, npop, nreq);
      for (int i = 0; i < n; i++) begin
         if (i < lg_n) begin
            chk($sformatf("%s cmd[%0d]", tag, i), lg_cmd[i], e_cmd[i]);
            chk($sformatf("%s bank[%0d]", tag, i), lg_bank[i], e_bank[i]);
            chk($sformatf("%s addr[%0d]", tag, i), lg_addr[i], e_addr[i]);
            chk($sformatf("%s clock[%0d]", tag, i), lg_cyc[i] - lg_cyc[0], e_rel[i]);
         end
      end
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      chk("R1 cmd in reset", int'(cmd_f), 0);
      chk("R1 pop in reset", int'(pop_f), 0);
      chk("R1 half cmd in reset", int'(cmd_h), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 idle cmd", int'(cmd_f), 0);
      chk("R2 idle pop", int'(pop_f), 0);
      @(posedge clk); #1;
   endtask

   // R3 R4 R5: write stream that crosses into a closed bank
   task automatic t_write_cross;
      qn = 0;
      push(0, 1'b1, 0, 5, 0); push(1, 1'b1, 0, 5, 8); push(2, 1'b1, 0, 5, 16);
      push(3, 1'b1, 1, 7, 0); push(4, 1'b1, 1, 7, 8);
      run_q(0, 5, 40);
      put(0, 1, 0, 5, 0);  put(1, 4, 0, 0, 3);  put(2, 4, 0, 8, 7);
      put(3, 1, 1, 7, 8);  put(4, 4, 0, 16, 11); put(5, 4, 1, 0, 15);
      put(6, 4, 1, 8, 19);
      cmp_trace("R3 R4 R5 write cross", 7, 5);
   endtask

   // R6: another row needed in a different, open bank
   task automatic t_lookahead_pre;
      qn = 0;
      push(0, 1'b0, 0, 5, 1); push(1, 1'b0, 0, 5, 2); push(2, 1'b0, 0, 5, 3);
      push(3, 1'b0, 1, 9, 4);
      run_q(0, 4, 40);
      put(0, 3, 0, 1, 0); put(1, 3, 0, 2, 4); put(2, 2, 1, 0, 5);
      put(3, 3, 0, 3, 8); put(4, 1, 1, 9, 9); put(5, 3, 1, 4, 12);
      cmp_trace("R6 lookahead precharge", 6, 4);
   endtask

   // R7 R2: direction changes on rows left open across idle time
   task automatic t_turnaround;
      qn = 0;
      push(0, 1'b0, 0, 5, 1); push(1, 1'b1, 0, 5, 2); push(2, 1'b1, 0, 5, 3);
      push(3, 1'b0, 1, 9, 4);
      run_q(0, 4, 40);
      put(0, 3, 0, 1, 0); put(1, 4, 0, 2, 6); put(2, 4, 0, 3, 10);
      put(3, 3, 1, 4, 16);
      cmp_trace("R7 R2 turnaround", 4, 4);
   endtask

   // R8: row conflict in one bank exposes the RAS and RP limits
   task automatic t_ras_rp;
      qn = 0;
      push(0, 1'b0, 2, 1, 0); push(1, 1'b0, 2, 2, 0);
      run_q(0, 2, 40);
      put(0, 1, 2, 1, 0); put(1, 3, 2, 0, 3); put(2, 2, 2, 0, 6);
      put(3, 1, 2, 2, 9); put(4, 3, 2, 0, 12);
      cmp_trace("R8 ras rp", 5, 2);
   endtask

   // R9: write-cross stream on the half-rate instance
   task automatic t_half;
      qn = 0;
      push(0, 1'b1, 0, 5, 0); push(1, 1'b1, 0, 5, 8); push(2, 1'b1, 0, 5, 16);
      push(3, 1'b1, 1, 7, 0); push(4, 1'b1, 1, 7, 8);
      run_q(1, 5, 40);
      put(0, 1, 0, 5, 0);  put(1, 4, 0, 0, 4);  put(2, 4, 0, 8, 8);
      put(3, 1, 1, 7, 10); put(4, 4, 0, 16, 12); put(5, 4, 1, 0, 16);
      put(6, 4, 1, 8, 20);
      cmp_trace("R9 half rate", 7, 5);
      for (int i = 1; i < lg_n; i++)
         chk($sformatf("R9 even spacing[%0d]", i), (lg_cyc[i] - lg_cyc[i-1]) % 2, 0);
   endtask

   initial begin
      t_reset();
      t_write_cross();
      t_lookahead_pre();
      t_turnaround();
      t_ras_rp();
      t_half();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog R1..all actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule